// File: doc/BRIEF.md
# E1 CRC-4 Receive Checker and E-bit Generator

This block sits behind the frame and multiframe alignment logic of an E1 receiver. It takes the aligned serial bit stream, one bit per enabled clock, together with the frame number inside the 16-frame multiframe and the bit position inside the 256-bit frame. Each multiframe splits into two sub-multiframes of eight frames. The block computes the CRC-4 remainder of every complete sub-multiframe. It then compares that remainder with the four check bits that the far end places in the following sub-multiframe.

Each comparison yields a local error indication. The block reports it in three ways: a one-cycle error pulse, a saturating error count, and an E-bit value for the transmit side. The result for the first sub-multiframe of a multiframe is routed to the first E-bit slot, and the result for the second to the second slot. The block also watches the E bits that arrive from the far end. It turns every zero E bit into a far-end block error pulse. It does this whatever the local CRC outcome of the sub-multiframe that carries the E bit.

Top module: `e1_crc4_rx_checker`

## Requirements
- R1: The remainder is that of the sub-multiframe's 2048 bits, multiplied by x^4, divided by x^4 + x + 1. Bits enter in arrival order: frame 0 bit position 0 first, bit position counting from 0 at the first bit of time slot 0. The remainder register is cleared at the first bit of frame 0 and of frame 8. The four check-bit positions (bit position 0 of the even frames) count as zero.
- R2: The received check bits are taken at bit position 0 of frames 0, 2, 4 and 6 (or 8, 10, 12 and 14) of the next sub-multiframe. The first of these is the most significant bit. On the cycle after the fourth check bit is accepted, the matching E-bit output shows 1 if the received bits equal the stored remainder and 0 if they differ.
- R3: A comparison completed during frames 0 to 7 reports on the second sub-multiframe of the previous multiframe. It updates `eBit2` and pulses `eBit2Valid`. A comparison completed during frames 8 to 15 updates `eBit1` and pulses `eBit1Valid`. The two valid pulses never occur together.
- R4: Both E-bit outputs reset to 1 and hold their value between updates. Every stored remainder is reported before the next sub-multiframe closes, which is far below the one-second limit.
- R5: `crcErr` is high for exactly one cycle for each failed comparison, on the same cycle as the E-bit update, and is low otherwise.
- R6: `errCount` resets to 0. It increments by one with each `crcErr` pulse and stops at its all-ones value.
- R7: A received bit of 0 at bit position 0 of frame 13 or frame 15 gives a one-cycle `farEndErr` pulse on the next cycle. This does not depend on the CRC result of the sub-multiframe that carries it.
- R8: Cycles with `bitValid` low change nothing. Processing starts at the first bit of frame 0 or frame 8 after reset. No comparison takes place until one complete sub-multiframe has been processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | A received bit is present this cycle |
| rxData | input | 1 | Received serial bit |
| frameNum | input | 4 | Frame number within the multiframe, 0 to 15 |
| bitPos | input | POS_W (8) | Bit position within the frame, 0 to FRAME_BITS-1 |
| eBit1 | output | 1 | E-bit value for the first slot (first sub-multiframe result) |
| eBit1Valid | output | 1 | One-cycle strobe when eBit1 is updated |
| eBit2 | output | 1 | E-bit value for the second slot (second sub-multiframe result) |
| eBit2Valid | output | 1 | One-cycle strobe when eBit2 is updated |
| crcErr | output | 1 | One-cycle pulse per failed sub-multiframe |
| errCount | output | CNT_W (16) | Saturating count of CRC failures |
| farEndErr | output | 1 | One-cycle pulse per received E bit equal to 0 |

## Verification
The bound properties are checked on every cycle. They cover the exclusive routing of the two valid strobes, and the agreement of each E-bit value with the error pulse. They also cover the E bits holding between updates, the counter's single-step and saturation behaviour, single-cycle far-end pulses, and the bound that each stored remainder is reported before the next sub-multiframe closes. Whether a remainder is numerically correct for the bits received, and whether a check is routed to the right slot for its position in the multiframe, can only be shown by the bench. It drives a stream that begins mid-frame, contains idle cycles, carries deliberately corrupted check bits and random far-end E bits, and compares every output against a behavioural model on every clock.

// File: rtl/e1crc_pkg.sv
package e1crc_pkg;

  // Per-bit strobes that the position decoder hands to the datapath.
  typedef struct packed {
    logic shift;    // accept this bit into the remainder
    logic clear;    // first bit of a sub-multiframe: start from zero
    logic zeroBit;  // check-bit position: counts as zero in the remainder
    logic capC;     // capture a received check bit
    logic latch;    // last bit of a sub-multiframe: store the remainder
    logic compare;  // fourth check bit: compare with the stored remainder
    logic toSlot2;  // comparison reports on the second sub-multiframe
    logic eSlot;    // far-end E bit position
  } crcStrobes_t;

endpackage

// File: rtl/crc4_ctrl.sv
module crc4_ctrl
  import e1crc_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic [3:0]       frameNum,
  input  logic [POS_W-1:0] bitPos,
  output crcStrobes_t      strb
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic synced;
  logic smfStart;
  logic inSync;
  logic firstBit;
  logic fasBit;
  logic lastBit;

  assign firstBit = (bitPos == '0);
  assign lastBit  = (bitPos == LAST_POS);
  assign smfStart = firstBit && (frameNum[2:0] == 3'd0);
  assign fasBit   = firstBit && !frameNum[0];
  assign inSync   = synced || smfStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      synced <= 1'b0;
    end else if (bitValid && smfStart) begin
      synced <= 1'b1;
    end
  end

  always_comb begin
    strb         = '0;
    strb.shift   = bitValid && inSync;
    strb.clear   = smfStart;
    strb.zeroBit = fasBit;
    strb.capC    = bitValid && inSync && fasBit;
    strb.latch   = bitValid && inSync && lastBit && (frameNum[2:0] == 3'd7);
    strb.compare = bitValid && inSync && fasBit && (frameNum[2:1] == 2'd3);
    strb.toSlot2 = !frameNum[3];
    strb.eSlot   = bitValid && inSync && firstBit &&
                   (frameNum[3:2] == 2'b11) && frameNum[0];
  end

endmodule

// File: rtl/crc4_datapath.sv
module crc4_datapath
  import e1crc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxData,
  input  crcStrobes_t      strb,
  output logic             eBit1,
  output logic             eBit1Valid,
  output logic             eBit2,
  output logic             eBit2Valid,
  output logic             crcErr,
  output logic [CNT_W-1:0] errCount,
  output logic             farEndErr,
  output logic             pendValid
);

  localparam int               CRC_W   = 4;
  localparam logic [CRC_W-1:0] POLY_LO = 4'b0011;   // x + 1 terms of x^4+x+1
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] crcSeed;
  logic [CRC_W-1:0] crcNext;
  logic [CRC_W-1:0] pendCrc;
  logic [CRC_W-2:0] rxC;
  logic [CRC_W-1:0] rxWord;
  logic             dIn;
  logic             fb;
  logic             match;
  logic             doCheck;

  assign crcSeed = strb.clear ? '0 : crcReg;
  assign dIn     = strb.zeroBit ? 1'b0 : rxData;
  assign fb      = crcSeed[CRC_W-1] ^ dIn;
  assign crcNext = {crcSeed[CRC_W-2:0], 1'b0} ^ (fb ? POLY_LO : '0);

  assign rxWord  = {rxC, rxData};
  assign match   = (rxWord == pendCrc);
  assign doCheck = strb.compare && pendValid;

  // Remainder register and stored remainder of the last full sub-multiframe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg    <= '0;
      pendCrc   <= '0;
      pendValid <= 1'b0;
      rxC       <= '0;
    end else begin
      if (strb.shift) begin
        crcReg <= crcNext;
      end
      if (strb.latch) begin
        pendCrc   <= crcNext;
        pendValid <= 1'b1;
      end
      if (strb.capC) begin
        rxC <= {rxC[CRC_W-3:0], rxData};
      end
    end
  end

  // Result routing to the E-bit slots, error pulse and counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      eBit1      <= 1'b1;
      eBit2      <= 1'b1;
      eBit1Valid <= 1'b0;
      eBit2Valid <= 1'b0;
      crcErr     <= 1'b0;
      errCount   <= '0;
      farEndErr  <= 1'b0;
    end else begin
      eBit1Valid <= 1'b0;
      eBit2Valid <= 1'b0;
      crcErr     <= 1'b0;
      farEndErr  <= strb.eSlot && !rxData;
      if (doCheck) begin
        crcErr <= !match;
        if (strb.toSlot2) begin
          eBit2      <= match;
          eBit2Valid <= 1'b1;
        end else begin
          eBit1      <= match;
          eBit1Valid <= 1'b1;
        end
        if (!match && (errCount != CNT_MAX)) begin
          errCount <= errCount + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/e1_crc4_rx_checker.sv
module e1_crc4_rx_checker
  import e1crc_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int CNT_W      = 16,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             rxData,
  input  logic [3:0]       frameNum,
  input  logic [POS_W-1:0] bitPos,
  output logic             eBit1,
  output logic             eBit1Valid,
  output logic             eBit2,
  output logic             eBit2Valid,
  output logic             crcErr,
  output logic [CNT_W-1:0] errCount,
  output logic             farEndErr
);

  crcStrobes_t strb;
  logic        pendValid;

  crc4_ctrl #(
    .FRAME_BITS(FRAME_BITS),
    .POS_W     (POS_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitValid(bitValid),
    .frameNum(frameNum),
    .bitPos  (bitPos),
    .strb    (strb)
  );

  crc4_datapath #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxData    (rxData),
    .strb      (strb),
    .eBit1     (eBit1),
    .eBit1Valid(eBit1Valid),
    .eBit2     (eBit2),
    .eBit2Valid(eBit2Valid),
    .crcErr    (crcErr),
    .errCount  (errCount),
    .farEndErr (farEndErr),
    .pendValid (pendValid)
  );

endmodule

// File: rtl/e1crc_props.sv
module e1crc_props
  import e1crc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SMF_BITS = 2048
) (
  input logic             clk,
  input logic             rstN,
  input logic             bitValid,
  input crcStrobes_t      strb,
  input logic             eBit1,
  input logic             eBit1Valid,
  input logic             eBit2,
  input logic             eBit2Valid,
  input logic             crcErr,
  input logic [CNT_W-1:0] errCount,
  input logic             farEndErr
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int               WAIT_W  = $clog2(SMF_BITS + 2) + 1;

  // Tracks a stored remainder that has not yet been reported
  logic              openRes;
  logic [WAIT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openRes <= 1'b0;
      waitCnt <= '0;
    end else if (strb.latch) begin
      openRes <= 1'b1;
      waitCnt <= '0;
    end else if (eBit1Valid || eBit2Valid) begin
      openRes <= 1'b0;
      waitCnt <= '0;
    end else if (openRes && bitValid) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  p_slots_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(eBit1Valid && eBit2Valid));

  p_ebit1_vs_err_r2: assert property (@(posedge clk) disable iff (!rstN)
    eBit1Valid |-> (eBit1 == !crcErr));

  p_ebit2_vs_err_r2: assert property (@(posedge clk) disable iff (!rstN)
    eBit2Valid |-> (eBit2 == !crcErr));

  p_err_needs_update_r5: assert property (@(posedge clk) disable iff (!rstN)
    crcErr |-> (eBit1Valid || eBit2Valid));

  p_ebit1_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !eBit1Valid |-> $stable(eBit1));

  p_ebit2_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !eBit2Valid |-> $stable(eBit2));

  p_report_before_next_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.latch |-> !openRes);

  p_report_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= WAIT_W'(SMF_BITS));

  p_cnt_only_on_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    (errCount != $past(errCount)) |-> crcErr);

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (crcErr && ($past(errCount) != CNT_MAX)) |-> (errCount == $past(errCount) + 1'b1));

  p_cnt_saturate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == CNT_MAX) |=> (errCount == CNT_MAX));

  p_far_end_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    farEndErr |=> !farEndErr);

endmodule

bind e1_crc4_rx_checker e1crc_props #(
  .CNT_W   (CNT_W),
  .SMF_BITS(8 * FRAME_BITS)
) u_props (
  .clk       (clk),
  .rstN      (rstN),
  .bitValid  (bitValid),
  .strb      (strb),
  .eBit1     (eBit1),
  .eBit1Valid(eBit1Valid),
  .eBit2     (eBit2),
  .eBit2Valid(eBit2Valid),
  .crcErr    (crcErr),
  .errCount  (errCount),
  .farEndErr (farEndErr)
);

// File: tb/sim_e1_crc4_rx_checker.sv
module sim_e1_crc4_rx_checker;

  localparam int CLK_PERIOD = 10;
  localparam int FB         = 256;
  localparam int PW         = $clog2(FB);
  localparam int CW         = 3;
  localparam int SMF_BITS   = 8 * FB;
  localparam int NUM_MF     = 10;
  localparam int WATCHDOG   = 150000;

  logic          clk = 1'b0;
  logic          rstN;
  logic          bitValid;
  logic          rxData;
  logic [3:0]    frameNum;
  logic [PW-1:0] bitPos;
  logic          eBit1, eBit1Valid, eBit2, eBit2Valid, crcErr, farEndErr;
  logic [CW-1:0] errCount;

  always #(CLK_PERIOD / 2) clk = ~clk;

  e1_crc4_rx_checker #(.FRAME_BITS(FB), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .rxData(rxData),
    .frameNum(frameNum), .bitPos(bitPos),
    .eBit1(eBit1), .eBit1Valid(eBit1Valid), .eBit2(eBit2), .eBit2Valid(eBit2Valid),
    .crcErr(crcErr), .errCount(errCount), .farEndErr(farEndErr)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // Remainder of M(x)*x^4 modulo x^4+x+1 by plain long division
  function automatic logic [3:0] polyRem(input logic [SMF_BITS-1:0] m);
    int r = 0;
    for (int i = 0; i < SMF_BITS + 4; i++) begin
      r = (r << 1) | ((i < SMF_BITS) ? int'(m[i]) : 0);
      if ((r & 16) != 0) r = r ^ 19;
    end
    return 4'(r);
  endfunction

  // ---------------- behavioural reference model ----------------
  logic               xE1, xE1V, xE2, xE2V, xErr, xFe;
  int                 xCnt;
  bit                 mSync, mPend;
  logic [3:0]         mPendCrc;
  logic [SMF_BITS-1:0] mBits;
  bit                 mRx[4];

  always @(posedge clk) begin
    if (!rstN) begin
      xE1 = 1; xE2 = 1; xE1V = 0; xE2V = 0; xErr = 0; xFe = 0; xCnt = 0;
      mSync = 0; mPend = 0; mPendCrc = 0;
    end else begin
      xE1V = 0; xE2V = 0; xErr = 0; xFe = 0;
      if (bitValid) begin
        automatic int f = int'(frameNum);
        automatic int b = int'(bitPos);
        automatic bit cPos = (b == 0) && (f % 2 == 0);
        if (b == 0 && f % 8 == 0) mSync = 1;
        if (mSync) begin
          mBits[(f % 8) * FB + b] = cPos ? 1'b0 : rxData;
          if (cPos) mRx[(f % 8) / 2] = rxData;
          if (cPos && f % 8 == 6 && mPend) begin
            automatic logic [3:0] got = {mRx[0], mRx[1], mRx[2], mRx[3]};
            automatic bit ok = (got == mPendCrc);
            if (f < 8) begin xE2 = ok; xE2V = 1; end
            else begin xE1 = ok; xE1V = 1; end
            xErr = !ok;
            if (!ok && xCnt < (1 << CW) - 1) xCnt++;
          end
          if (b == FB - 1 && f % 8 == 7) begin
            mPendCrc = polyRem(mBits);
            mPend = 1;
          end
          if (b == 0 && (f == 13 || f == 15) && rxData == 1'b0) xFe = 1;
        end
      end
    end
  end

  // ---------------- checks ----------------
  int seenErr = 0;
  int seenFe  = 0;
  int earlyV  = 0;
  int genK    = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmpOutputs();
    chk(eBit1 === xE1, "R3", "eBit1", int'(eBit1), int'(xE1));
    chk(eBit1Valid === xE1V, "R3", "eBit1Valid", int'(eBit1Valid), int'(xE1V));
    chk(eBit2 === xE2, "R2", "eBit2", int'(eBit2), int'(xE2));
    chk(eBit2Valid === xE2V, "R2", "eBit2Valid", int'(eBit2Valid), int'(xE2V));
    chk(crcErr === xErr, "R1 R5", "crcErr", int'(crcErr), int'(xErr));
    chk(int'(errCount) == xCnt, "R6", "errCount", int'(errCount), xCnt);
    chk(farEndErr === xFe, "R7", "farEndErr", int'(farEndErr), int'(xFe));
    if (crcErr === 1'b1) seenErr++;
    if (farEndErr === 1'b1) seenFe++;
    if (genK < 2 && (eBit1Valid === 1'b1 || eBit2Valid === 1'b1)) earlyV++;
  endtask

  task automatic step(input bit v, input bit d, input int f, input int b);
    @(negedge clk);
    cmpOutputs();
    bitValid = v;
    rxData   = d;
    frameNum = 4'(f);
    bitPos   = PW'(b);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  logic [SMF_BITS-1:0] gBits;
  logic [3:0]          gPrevCrc;
  int                  corruptCnt = 0;
  int                  eZeroCnt   = 0;

  initial begin
    rstN = 1'b0; bitValid = 1'b0; rxData = 1'b0; frameNum = '0; bitPos = '0;
    gPrevCrc = '0;
    gBits = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R4 R6: reset state
    chk(eBit1 === 1'b1 && eBit2 === 1'b1, "R4", "E bits after reset",
        int'({eBit1, eBit2}), 3);
    chk(errCount == '0, "R6", "count after reset", int'(errCount), 0);
    chk(!crcErr && !eBit1Valid && !eBit2Valid && !farEndErr, "R5", "pulses after reset",
        int'({crcErr, eBit1Valid, eBit2Valid, farEndErr}), 0);

    // Stream starts mid-frame (R8) and includes idle cycles
    for (int mf = 0; mf < NUM_MF; mf++) begin
      for (int f = 0; f < 16; f++) begin
        for (int b = 0; b < FB; b++) begin
          automatic bit d;
          automatic bit cPos = (b == 0) && (f % 2 == 0);
          automatic bit corrupt;
          if (mf == 0 && (f < 3 || (f == 3 && b < 100))) continue;
          genK = mf * 2 + f / 8;
          corrupt = (genK >= 2) && (genK % 2 == 0);
          if (cPos) begin
            if (genK >= 2) d = gPrevCrc[3 - (f % 8) / 2];
            else d = 1'($urandom);
            if (corrupt && f % 8 == 2) d = !d;
            if (corrupt && f % 8 == 0 && b == 0) corruptCnt++;
          end else if (b == 0 && (f == 13 || f == 15)) begin
            d = ($urandom % 3) != 0;
            if (!d) eZeroCnt++;
          end else begin
            d = 1'($urandom);
          end
          gBits[(f % 8) * FB + b] = cPos ? 1'b0 : d;
          if ($urandom % 10 == 0) begin
            // R8: an idle cycle carrying a wrong bit must change nothing
            step(1'b0, !d, f, b);
          end
          step(1'b1, d, f, b);
          if (b == FB - 1 && f % 8 == 7) gPrevCrc = polyRem(gBits);
        end
      end
    end
    repeat (4) step(1'b0, 1'b0, 0, 1);
    done = 1'b1;

    chk(seenErr == corruptCnt, "R2", "failed sub-multiframes", seenErr, corruptCnt);
    chk(int'(errCount) == (1 << CW) - 1, "R6", "saturated count",
        int'(errCount), (1 << CW) - 1);
    chk(seenFe == eZeroCnt, "R7", "far-end pulses", seenFe, eZeroCnt);
    chk(earlyV == 0, "R8", "checks before first full sub-multiframe", earlyV, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule